// File: doc/BRIEF.md
# Wrapping Line-Fill Burst Read Controller

This block sits between an on-chip requester and an external memory bus. It turns one internal request for a 32-byte line (eight 32-bit words) into the external burst transfers needed to fetch it. Two configuration bits are captured when a request is accepted. One selects a 32-bit or 16-bit external data port. The other selects an external burst of eight words, or two back-to-back bursts of four words that each wrap inside their own 4-word block. The first word fetched is chosen by two bits of the request address, so the critical word arrives first.

The external side provides a transfer-start pulse, a chip-select, a per-beat address and a burst-in-progress strobe. The strobe is released early, on the beat before the last, so that the memory stops after one more beat. Beats are counted only when the memory acknowledges them. Returned data is stored by word address, so the requester always sees the line in natural word order. A one-cycle done pulse marks completion. The busy output also holds off bus arbitration, and it stays high across the gap between the two short bursts, which makes the pair atomic. A write is always a single beat with the strobe low.

Top module: `xmem_burst_rd`

## Requirements
- R1: With a 32-bit port and the 8-word setting, a read performs exactly one transfer start and eight acknowledged beats.
- R2: With a 16-bit port, every word takes two beats, so twice as many beats are needed. The beat at byte offset 0 of a word (ext_addr bit 1 low) carries bits 31:16, and the beat at offset 2 carries bits 15:0. Each half is taken from ext_rdata[15:0].
- R3: With the 4-word setting, a read performs two transfer starts of four words each. The first burst wraps inside the 4-word block that holds the start word. The second burst covers the other block, starting at the same offset within it.
- R4: busy rises in the cycle after acceptance and stays high without a gap until the final beat of the final burst is acknowledged, including between the two short bursts. A request raised while busy has no effect.
- R5: During a read data phase, ext_burst is high while more than one beat remains in the current burst. It is low after the next-to-last beat has been acknowledged, and it is never high outside the data phase.
- R6: Request address bits [4:3] = n make word 2n the first word, and the words then follow in ascending order modulo the burst span.
- R7: A write is one beat at the request address, with ext_we high, ext_wdata equal to the request data and ext_burst low.
- R8: One cycle after the final acknowledge, done is high for exactly one cycle with busy low. At that point rd_line holds word i in bits [32i+31:32i], whatever order the words arrived in.
- R9: The beat count advances only on cycles with ext_ack high. Cycles without an acknowledge stretch the burst without changing its length or its address sequence.
- R10: Reset, whether at start-up or in the middle of a burst, leaves busy, done, ext_cs, ext_start, ext_we and ext_burst low and clears rd_line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = single-beat write, 0 = line read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | 32 | Write data |
| cfg_half_port | input | 1 | 1 = 16-bit external port |
| cfg_short_burst | input | 1 | 1 = two 4-word bursts instead of one 8-word burst |
| busy | output | 1 | Transfer in progress; arbitration held off |
| done | output | 1 | One-cycle completion pulse |
| rd_line | output | 256 | Fetched line, natural word order |
| ext_addr | output | ADDR_W | Byte address of the current beat |
| ext_cs | output | 1 | Chip select, high for a whole transfer |
| ext_start | output | 1 | One-cycle transfer-start pulse per burst |
| ext_we | output | 1 | Write cycle indication |
| ext_burst | output | 1 | Burst-data-in-progress strobe |
| ext_wdata | output | 32 | Write data to memory |
| ext_ack | input | 1 | Beat acknowledge from memory |
| ext_rdata | input | 32 | Read data from memory |

## Verification
A request sampled at a rising edge raises busy and ext_start in the next cycle. The data phase, and with it the earliest acknowledge, follows one cycle later. A second short burst starts in the cycle after the last acknowledge of the first. done and the complete rd_line appear in the cycle after the final acknowledge. The bench drives inputs and reads outputs at falling edges. It plays the memory itself, recording ext_addr, ext_burst and ext_we in each cycle where it acknowledges. It checks done and rd_line in the first cycle done is seen, then confirms that done has dropped one cycle later.

// File: rtl/xmb_pkg.sv
package xmb_pkg;
    localparam int WORD_W     = 32;
    localparam int HALF_W     = WORD_W / 2;
    localparam int LINE_WORDS = 8;
    localparam int WIDX_W     = $clog2(LINE_WORDS);
    localparam int BEAT_W     = WIDX_W + 1;
    localparam int LINE_BYTES = LINE_WORDS * WORD_W / 8;
    localparam int OFS_W      = $clog2(LINE_BYTES);
    localparam int LINE_W     = LINE_WORDS * WORD_W;

    typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA} xmb_state_e;

    typedef struct packed {
        logic half_port;
        logic short_bl;
        logic write;
    } xmb_cfg_t;

    typedef struct packed {
        logic              en;
        logic [WIDX_W-1:0] widx;
        logic              half;
        logic              upper;
    } xmb_wr_t;

    // index of the final beat in one external burst
    function automatic logic [BEAT_W-1:0] last_beat(input xmb_cfg_t c);
        logic [WIDX_W-1:0] wm1;
        wm1 = c.short_bl ? WIDX_W'(LINE_WORDS/2 - 1) : WIDX_W'(LINE_WORDS - 1);
        if (c.write)
            return '0;
        return c.half_port ? {wm1, 1'b1} : {1'b0, wm1};
    endfunction

    // word index for step k of sub-burst sub, given the critical start word
    function automatic logic [WIDX_W-1:0] wrap_word(input logic [WIDX_W-1:0] start,
                                                     input logic              sub,
                                                     input logic [WIDX_W-1:0] k,
                                                     input logic              short_bl);
        logic [WIDX_W-1:0] full_w;
        logic [WIDX_W-2:0] low;
        full_w = start + k;
        low    = start[WIDX_W-2:0] + k[WIDX_W-2:0];
        return short_bl ? {start[WIDX_W-1] ^ sub, low} : full_w;
    endfunction
endpackage

// File: rtl/xmb_seq.sv
module xmb_seq
    import xmb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              cfg_half_port,
    input  logic              cfg_short_burst,
    input  logic              ext_ack,
    output xmb_state_e        st,
    output xmb_cfg_t          cfg_q,
    output logic              sub,
    output logic [BEAT_W-1:0] beat,
    output logic [ADDR_W-1:0] addr_q,
    output logic              done
);
    logic [BEAT_W-1:0] beat_end;
    logic              final_sub;

    assign beat_end  = last_beat(cfg_q);
    assign final_sub = cfg_q.write || !cfg_q.short_bl || sub;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cfg_q  <= '0;
            sub    <= 1'b0;
            beat   <= '0;
            addr_q <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: if (req_valid) begin
                    st     <= ST_ADDR;
                    cfg_q  <= '{half_port: cfg_half_port,
                                short_bl:  cfg_short_burst,
                                write:     req_write};
                    addr_q <= req_addr;
                    sub    <= 1'b0;
                    beat   <= '0;
                end
                ST_ADDR: st <= ST_DATA;
                ST_DATA: if (ext_ack) begin
                    if (beat == beat_end) begin
                        beat <= '0;
                        if (final_sub) begin
                            st   <= ST_IDLE;
                            done <= 1'b1;
                        end else begin
                            sub <= 1'b1;
                            st  <= ST_ADDR;
                        end
                    end else begin
                        beat <= beat + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R9: no acknowledge, no progress
    a_r9_beat_hold: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DATA && !ext_ack) |=> (st == ST_DATA && beat == $past(beat)));

    // R3: first short burst chains straight into the second
    a_r3_chain: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DATA && ext_ack && beat == beat_end && !final_sub)
        |=> (st == ST_ADDR && sub));

    // R1: beat index stays inside the burst
    a_r1_beat_bound: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DATA) |-> (beat <= beat_end));

    // R8: completion only from an idle controller
    a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> (st == ST_IDLE));
endmodule

// File: rtl/xmb_addr_gen.sv
module xmb_addr_gen
    import xmb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  xmb_state_e        st,
    input  xmb_cfg_t          cfg_q,
    input  logic              sub,
    input  logic [BEAT_W-1:0] beat,
    input  logic [ADDR_W-1:0] addr_q,
    output logic [WIDX_W-1:0] widx,
    output logic [ADDR_W-1:0] beat_addr,
    output logic              strobe
);
    logic [WIDX_W-1:0] start_w;
    logic [WIDX_W-1:0] step;

    // critical word: two address bits pick an even word
    assign start_w = {addr_q[OFS_W-1 -: WIDX_W-1], 1'b0};
    assign step    = cfg_q.half_port ? beat[BEAT_W-1:1] : beat[WIDX_W-1:0];
    assign widx    = wrap_word(start_w, sub, step, cfg_q.short_bl);

    always_comb begin
        if (cfg_q.write)
            beat_addr = addr_q;
        else
            beat_addr = {addr_q[ADDR_W-1:OFS_W], widx, cfg_q.half_port & beat[0], 1'b0};
    end

    assign strobe = (st == ST_DATA) && !cfg_q.write && (beat != last_beat(cfg_q));
endmodule

// File: rtl/xmb_collect.sv
module xmb_collect
    import xmb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  xmb_wr_t           wr,
    input  logic [WORD_W-1:0] ext_rdata,
    output logic [LINE_W-1:0] line
);
    logic [LINE_WORDS-1:0] wen;

    for (genvar i = 0; i < LINE_WORDS; i++) begin : g_word
        logic [WORD_W-1:0] word_q;

        assign wen[i] = wr.en && (wr.widx == WIDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (wen[i]) begin
                if (!wr.half)
                    word_q <= ext_rdata;
                else if (wr.upper)
                    word_q[WORD_W-1:HALF_W] <= ext_rdata[HALF_W-1:0];
                else
                    word_q[HALF_W-1:0] <= ext_rdata[HALF_W-1:0];
            end
        end

        assign line[i*WORD_W +: WORD_W] = word_q;
    end

    // R8: each beat lands in at most one word slot
    a_r8_one_slot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wen));
endmodule

// File: rtl/xmem_burst_rd.sv
module xmem_burst_rd
    import xmb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic              cfg_half_port,
    input  logic              cfg_short_burst,
    output logic              busy,
    output logic              done,
    output logic [255:0]      rd_line,
    output logic [ADDR_W-1:0] ext_addr,
    output logic              ext_cs,
    output logic              ext_start,
    output logic              ext_we,
    output logic              ext_burst,
    output logic [31:0]       ext_wdata,
    input  logic              ext_ack,
    input  logic [31:0]       ext_rdata
);
    xmb_state_e        st;
    xmb_cfg_t          cfg_q;
    logic              sub;
    logic [BEAT_W-1:0] beat;
    logic [ADDR_W-1:0] addr_q;
    logic [WIDX_W-1:0] widx;
    xmb_wr_t           wr;

    xmb_seq #(.ADDR_W(ADDR_W)) i_seq (
        .clk             (clk),
        .rst             (rst),
        .req_valid       (req_valid),
        .req_write       (req_write),
        .req_addr        (req_addr),
        .cfg_half_port   (cfg_half_port),
        .cfg_short_burst (cfg_short_burst),
        .ext_ack         (ext_ack),
        .st              (st),
        .cfg_q           (cfg_q),
        .sub             (sub),
        .beat            (beat),
        .addr_q          (addr_q),
        .done            (done)
    );

    xmb_addr_gen #(.ADDR_W(ADDR_W)) i_addr (
        .st        (st),
        .cfg_q     (cfg_q),
        .sub       (sub),
        .beat      (beat),
        .addr_q    (addr_q),
        .widx      (widx),
        .beat_addr (ext_addr),
        .strobe    (ext_burst)
    );

    assign wr = '{en:    (st == ST_DATA) && ext_ack && !cfg_q.write,
                  widx:  widx,
                  half:  cfg_q.half_port,
                  upper: !beat[0]};

    xmb_collect i_collect (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .ext_rdata (ext_rdata),
        .line      (rd_line)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ext_wdata <= '0;
        else if (st == ST_IDLE && req_valid)
            ext_wdata <= req_wdata;
    end

    assign ext_cs    = (st != ST_IDLE);
    assign ext_start = (st == ST_ADDR);
    assign ext_we    = ext_cs && cfg_q.write;
    assign busy      = ext_cs;

    // R7: writes never raise the burst strobe
    a_r7_write_no_strobe: assert property (@(posedge clk) disable iff (rst)
        ext_we |-> !ext_burst);

    // R5: strobe confined to the data phase of a selected transfer
    a_r5_strobe_in_data: assert property (@(posedge clk) disable iff (rst)
        ext_burst |-> (ext_cs && !ext_start));

    // R4: start pulse lasts a single cycle
    a_r4_start_single: assert property (@(posedge clk) disable iff (rst)
        ext_start |=> !ext_start);

    // R8: completion coincides with a released bus
    a_r8_done_released: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

// File: tb/test_xmem_burst_rd.sv
`timescale 1ns/1ps
module test_xmem_burst_rd;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [31:0]  req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic         cfg_half_port = 1'b0;
    logic         cfg_short_burst = 1'b0;
    logic         busy, done;
    logic [255:0] rd_line;
    logic [31:0]  ext_addr;
    logic         ext_cs, ext_start, ext_we, ext_burst;
    logic [31:0]  ext_wdata;
    logic         ext_ack = 1'b0;
    logic [31:0]  ext_rdata = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    xmem_burst_rd i_xmem_burst_rd (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .cfg_half_port(cfg_half_port),
        .cfg_short_burst(cfg_short_burst), .busy(busy), .done(done), .rd_line(rd_line),
        .ext_addr(ext_addr), .ext_cs(ext_cs), .ext_start(ext_start), .ext_we(ext_we),
        .ext_burst(ext_burst), .ext_wdata(ext_wdata), .ext_ack(ext_ack), .ext_rdata(ext_rdata)
    );

    // {sel[1:0], half, short, write, stall, mid_request}
    localparam logic [6:0] VEC [12] = '{
        7'b00_0_0_0_0_0, 7'b01_0_0_0_1_0, 7'b10_1_0_0_0_0, 7'b11_1_1_0_0_0,
        7'b01_0_1_0_0_0, 7'b10_0_1_0_1_0, 7'b11_1_0_0_0_0, 7'b00_1_1_0_1_0,
        7'b11_0_0_0_0_0, 7'b01_0_0_1_0_0, 7'b10_1_0_1_1_0, 7'b10_0_1_0_0_1
    };

    function automatic logic [31:0] memw(input logic [2:0] w);
        return {8'hA0 + 8'(w), 8'h5A, 8'h11 * 8'(w), 8'hC3};
    endfunction

    function automatic logic [31:0] exp_addr(input logic [31:0] base, input bit half,
                                             input bit shrt, input int i, input int bps);
        int s, j, k;
        logic [2:0] st, w;
        s  = i / bps;
        j  = i % bps;
        k  = half ? j / 2 : j;
        st = {base[4:3], 1'b0};
        if (shrt) w = {st[2] ^ s[0], 2'(st[1:0] + 2'(k))};
        else      w = 3'(st + 3'(k));
        return (base & ~32'h1F) | (32'(w) << 2) | ((half && (j % 2 == 1)) ? 32'd2 : 32'd0);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_case(input logic [1:0] sel, input bit half, input bit shrt,
                            input bit wr, input bit stall, input bit midreq);
        logic [31:0] base;
        logic [31:0] rec_a [32];
        logic        rec_s [32];
        int bps, subs, total, n_ack, n_start, cyc;
        bit got_done, busy_gap;
        string mtag;
        base  = 32'h1234_5600 | (32'(sel) << 3);
        bps   = wr ? 1 : (shrt ? 4 : 8) * (half ? 2 : 1);
        subs  = (wr || !shrt) ? 1 : 2;
        total = bps * subs;
        n_ack = 0; n_start = 0; cyc = 0; got_done = 0; busy_gap = 0;
        mtag  = wr ? "R7" : shrt ? "R3" : half ? "R2" : "R1";
        if (stall) mtag = {mtag, "/R9"};
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = base;
        req_wdata = 32'hCAFE_0000 | 32'(sel); cfg_half_port = half; cfg_short_burst = shrt;
        while (!got_done && cyc < 400) begin
            @(negedge clk);
            cyc++;
            req_valid = (midreq && cyc == 3);
            ext_ack = 1'b0;
            if (done) begin
                got_done = 1;
            end else begin
                if (!busy) busy_gap = 1;
                if (ext_start) n_start++;
                if (ext_cs && !ext_start && (!stall || cyc[0])) begin
                    logic [31:0] w;
                    ext_ack = 1'b1;
                    if (n_ack < 32) begin
                        rec_a[n_ack] = ext_addr;
                        rec_s[n_ack] = ext_burst;
                    end
                    chk(ext_we == wr, "R7 ext_we level at beat", 32'(ext_we), 32'(wr));
                    if (wr)
                        chk(ext_wdata == req_wdata, "R7 write data", ext_wdata, req_wdata);
                    n_ack++;
                    w = memw(ext_addr[4:2]);
                    if (half) ext_rdata = {16'hDEAD, ext_addr[1] ? w[15:0] : w[31:16]};
                    else      ext_rdata = w;
                end
            end
        end
        ext_ack = 1'b0; req_valid = 1'b0;
        chk(got_done, "R8 done pulse seen", 32'(got_done), 32'd1);
        if (got_done) begin
            chk(!busy, "R8 busy low with done", 32'(busy), 32'd0);
            chk(n_start == subs, {mtag, " transfer starts"}, 32'(n_start), 32'(subs));
            chk(n_ack == total, {mtag, " beat count"}, 32'(n_ack), 32'(total));
            chk(!busy_gap, "R4 busy held throughout", 32'(busy_gap), 32'd0);
            for (int i = 0; i < total && i < n_ack; i++) begin
                logic [31:0] ea;
                bit es;
                ea = wr ? base : exp_addr(base, half, shrt, i, bps);
                es = !wr && ((i % bps) != bps - 1);
                chk(rec_a[i] == ea, {"R6 ", mtag, " beat address"}, rec_a[i], ea);
                chk(rec_s[i] == es, wr ? "R7 strobe on write" : "R5 strobe at beat",
                    32'(rec_s[i]), 32'(es));
            end
            if (!wr) begin
                for (int i = 0; i < 8; i++)
                    chk(rd_line[i*32 +: 32] == memw(3'(i)), "R8 line word natural order",
                        rd_line[i*32 +: 32], memw(3'(i)));
            end
            @(negedge clk);
            chk(!done, "R8 done one cycle only", 32'(done), 32'd0);
            if (midreq) begin
                for (int i = 0; i < 5; i++) begin
                    chk(!ext_cs, "R4 request while busy ignored", 32'(ext_cs), 32'd0);
                    @(negedge clk);
                end
            end
        end
    endtask

    task automatic chk_idle(input string tag);
        chk(!busy && !done && !ext_cs && !ext_start && !ext_we && !ext_burst, tag,
            {26'd0, busy, done, ext_cs, ext_start, ext_we, ext_burst}, 32'd0);
        chk(rd_line == '0, {tag, " line cleared"}, rd_line[31:0], 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_idle("R10 reset state");
        rst = 1'b0;

        for (int v = 0; v < 12; v++)
            run_case(VEC[v][6:5], VEC[v][4], VEC[v][3], VEC[v][2], VEC[v][1], VEC[v][0]);

        // R10: reset in the middle of a 16-bit burst
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h0000_0040;
        cfg_half_port = 1'b1; cfg_short_burst = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) begin
            @(negedge clk);
            ext_ack = 1'b1; ext_rdata = 32'h0000_BEEF;
        end
        @(negedge clk);
        ext_ack = 1'b0;
        chk(busy && ext_burst, "R10 burst running before reset", 32'(busy), 32'd1);
        rst = 1'b1;
        @(negedge clk);
        chk_idle("R10 reset mid-burst");
        rst = 1'b0;

        // recovery after reset
        run_case(2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule